// File: doc/BRIEF.md
# Per-Bus Interrupt Status Unit

This block keeps the interrupt status register and the interrupt enable register of one serial bus channel and drives the channel's interrupt line. The bus sequencer and the target-side logic report events through one-cycle pulses: transmit acknowledged, transmit not acknowledged, receive complete, normal stop, abnormal stop and own-address match. Software programs the enable register and clears status bits by writing ones to the status register.

An interrupt is raised only at the moment an event arrives and the updated status has at least one enabled bit. Outside packet mode, raising the interrupt also drops every status bit whose enable is clear. The line stays high until the status register becomes all zero. Disabling the enable bits does not drop it. The block drives a per-bus contribution to a controller-wide summary vector, with the bit chosen by the bus number. When software clears a pending receive-complete while a receive command is still outstanding, the block emits a one-cycle pulse that tells the sequencer to fetch the next byte.

Top module: `bus_irq_status_unit`

## Requirements
- R1: After reset the status register, the enable register, the interrupt line and the summary output are all zero.
- R2: Event input index i sets status bit i. The indices are: 0 transmit ack, 1 transmit nak, 2 receive done, 3 normal stop, 4 abnormal stop, 5 address match. The new value is visible one cycle after the pulse. Any other status bits remain set.
- R3: The interrupt line rises one cycle after an event pulse when (status after the event) AND enable is nonzero.
- R4: When an interrupt is raised while packet mode is low, the status becomes (status after the event) AND enable. When packet mode is high, the status keeps every bit.
- R5: If an event leaves (status AND enable) at zero, the interrupt line is unchanged and the status keeps all of its bits.
- R6: A status write clears, one cycle later, every status bit written as 1 across the 15-bit field. Bits written as 0 are unchanged.
- R7: An enable write stores all 15 data bits one cycle later. An enable write on its own never changes the interrupt line.
- R8: The interrupt line and the summary bit fall in the cycle that the status register becomes all zero. They stay high while any status bit remains.
- R9: If an event pulse and a status write hit the same bit in the same cycle, the bit ends up set.
- R10: The re-arm output pulses high for exactly one cycle after a status write that writes 1 to bit 2 while bit 2 was set and the receive-pending input is high. In every other case it stays low.
- R11: The summary output has bit BUS_ID equal to the interrupt line, and all of its other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktMode | input | 1 | Packet mode; high keeps disabled status bits when an interrupt is raised |
| evtPulse | input | 6 | One-cycle event pulses, index i sets status bit i |
| wrStatus | input | 1 | Write strobe for the status register (write-one-to-clear) |
| wrEnable | input | 1 | Write strobe for the enable register |
| wrData | input | 15 | Write data shared by both registers |
| rxCmdPending | input | 1 | A receive or last-receive command is still outstanding |
| statusOut | output | 15 | Current status register |
| enableOut | output | 15 | Current enable register |
| irqOut | output | 1 | Interrupt line of this bus |
| summaryOut | output | NUM_BUSES | Contribution to the controller summary vector |
| rxRearm | output | 1 | One-cycle request to receive the next byte |

## Verification
Every result is due one clock edge after its stimulus. This applies to the status and enable registers, the interrupt line, the summary contribution and the re-arm pulse. The bench drives inputs on the falling edge and holds them through a single rising edge. It releases them on the next falling edge and reads the outputs there. Each value it reads is therefore the response to exactly one stimulus cycle. The sweep goes over packet mode, prior status patterns, all 64 enable patterns of the event bits and each event. It computes the expected status, line and summary arithmetically from R2 to R5. Directed sequences cover partial and full clears, set-over-clear and the re-arm cases.

// File: rtl/bus_irq_pkg.sv
package bus_irq_pkg;
  localparam int STS_W    = 15;
  localparam int NUM_EVT  = 6;
  localparam int EV_TXACK = 0;
  localparam int EV_TXNAK = 1;
  localparam int EV_RXDN  = 2;
  localparam int EV_STOP  = 3;
  localparam int EV_ABN   = 4;
  localparam int EV_ADDR  = 5;
  localparam logic [STS_W-1:0] WR_MASK = {STS_W{1'b1}};

  typedef struct packed {
    logic [STS_W-1:0] setMask;
    logic [STS_W-1:0] clrMask;
    logic [STS_W-1:0] enData;
    logic             enLoad;
    logic             discard;
    logic             raise;
    logic             lower;
  } ctrlStrb_t;
endpackage

// File: rtl/bus_irq_ctrl.sv
module bus_irq_ctrl
  import bus_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               pktMode,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               wrStatus,
  input  logic               wrEnable,
  input  logic [STS_W-1:0]   wrData,
  input  logic               rxCmdPending,
  input  logic [STS_W-1:0]   statusQ,
  input  logic [STS_W-1:0]   enableQ,
  output ctrlStrb_t          strb,
  output logic               rxRearm
);
  logic [STS_W-1:0] setVec;
  logic [STS_W-1:0] clrVec;
  logic [STS_W-1:0] cand;
  logic             anyEvt;
  logic             doRaise;
  logic             rearmQ;

  for (genvar g = 0; g < STS_W; g++) begin : gSet
    if (g < NUM_EVT) begin : gEvt
      assign setVec[g] = evtPulse[g];
    end else begin : gNone
      assign setVec[g] = 1'b0;
    end
  end

  assign clrVec  = wrStatus ? (wrData & WR_MASK) : '0;
  assign cand    = (statusQ & ~clrVec) | setVec;
  assign anyEvt  = |evtPulse;
  assign doRaise = anyEvt && (|(cand & enableQ));

  always_comb begin
    strb         = '0;
    strb.setMask = setVec;
    strb.clrMask = clrVec;
    strb.enData  = wrData & WR_MASK;
    strb.enLoad  = wrEnable;
    strb.raise   = doRaise;
    strb.discard = doRaise && !pktMode;
    strb.lower   = !doRaise && (cand == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) rearmQ <= 1'b0;
    else       rearmQ <= wrStatus && wrData[EV_RXDN] && statusQ[EV_RXDN] && rxCmdPending;
  end
  assign rxRearm = rearmQ;

  // R10: a re-arm pulse only follows a status write with a pending receive
  a_r10_rearm_cause: assert property (@(posedge clk) disable iff (!rstN)
    rxRearm |-> $past(wrStatus && rxCmdPending));

  // R2: in packet mode every pulsed event bit is present next cycle
  a_r2_set_kept: assert property (@(posedge clk) disable iff (!rstN)
    (anyEvt && pktMode) |=> ((statusQ & $past(setVec)) == $past(setVec)));
endmodule

// File: rtl/bus_irq_regs.sv
module bus_irq_regs
  import bus_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  output logic [STS_W-1:0] statusQ,
  output logic [STS_W-1:0] enableQ
);
  logic [STS_W-1:0] merged;

  assign merged = (statusQ & ~strb.clrMask) | strb.setMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= strb.discard ? (merged & enableQ) : merged;
      if (strb.enLoad) enableQ <= strb.enData;
    end
  end

  // R6: with no event, cleared bits are gone next cycle
  a_r6_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask == '0) |=> ((statusQ & $past(strb.clrMask)) == '0));

  // R7: an enable write lands next cycle
  a_r7_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.enLoad |=> (enableQ == $past(strb.enData)));
endmodule

// File: rtl/bus_irq_line.sv
module bus_irq_line #(
  parameter int NUM_BUSES = 4,
  parameter int BUS_ID    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 raise,
  input  logic                 lower,
  output logic                 lineQ,
  output logic [NUM_BUSES-1:0] summaryOut
);
  always_ff @(posedge clk) begin
    if (!rstN)      lineQ <= 1'b0;
    else if (raise) lineQ <= 1'b1;
    else if (lower) lineQ <= 1'b0;
  end

  for (genvar g = 0; g < NUM_BUSES; g++) begin : gSum
    if (g == BUS_ID) begin : gOwn
      assign summaryOut[g] = lineQ;
    end else begin : gOther
      assign summaryOut[g] = 1'b0;
    end
  end

  // R3: the line only rises after a raise decision
  a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineQ) |-> $past(raise));
endmodule

// File: rtl/bus_irq_status_unit.sv
module bus_irq_status_unit
  import bus_irq_pkg::*;
#(
  parameter int NUM_BUSES = 4,
  parameter int BUS_ID    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pktMode,
  input  logic [NUM_EVT-1:0]   evtPulse,
  input  logic                 wrStatus,
  input  logic                 wrEnable,
  input  logic [STS_W-1:0]     wrData,
  input  logic                 rxCmdPending,
  output logic [STS_W-1:0]     statusOut,
  output logic [STS_W-1:0]     enableOut,
  output logic                 irqOut,
  output logic [NUM_BUSES-1:0] summaryOut,
  output logic                 rxRearm
);
  ctrlStrb_t        strb;
  logic [STS_W-1:0] statusQ;
  logic [STS_W-1:0] enableQ;
  logic             lineQ;

  bus_irq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pktMode(pktMode), .evtPulse(evtPulse),
    .wrStatus(wrStatus), .wrEnable(wrEnable), .wrData(wrData),
    .rxCmdPending(rxCmdPending), .statusQ(statusQ), .enableQ(enableQ),
    .strb(strb), .rxRearm(rxRearm)
  );

  bus_irq_regs regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .statusQ(statusQ), .enableQ(enableQ)
  );

  bus_irq_line #(.NUM_BUSES(NUM_BUSES), .BUS_ID(BUS_ID)) line_i (
    .clk(clk), .rstN(rstN), .raise(strb.raise), .lower(strb.lower),
    .lineQ(lineQ), .summaryOut(summaryOut)
  );

  assign statusOut = statusQ;
  assign enableOut = enableQ;
  assign irqOut    = lineQ;

  // R8: an empty status register never coexists with a high line
  a_r8_zero_low: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ == '0) |-> !irqOut);
endmodule

// File: tb/bus_irq_status_unit_tb_top.sv
module bus_irq_status_unit_tb_top;
  localparam int NB  = 4;
  localparam int BID = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktMode = 1'b0;
  logic [5:0]  evtPulse = '0;
  logic        wrStatus = 1'b0;
  logic        wrEnable = 1'b0;
  logic [14:0] wrData = '0;
  logic        rxCmdPending = 1'b0;
  logic [14:0] statusOut;
  logic [14:0] enableOut;
  logic        irqOut;
  logic [NB-1:0] summaryOut;
  logic        rxRearm;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bus_irq_status_unit #(.NUM_BUSES(NB), .BUS_ID(BID)) dut_i (
    .clk(clk), .rstN(rstN), .pktMode(pktMode), .evtPulse(evtPulse),
    .wrStatus(wrStatus), .wrEnable(wrEnable), .wrData(wrData),
    .rxCmdPending(rxCmdPending), .statusOut(statusOut), .enableOut(enableOut),
    .irqOut(irqOut), .summaryOut(summaryOut), .rxRearm(rxRearm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply for one rising edge; return on the following falling edge
  task automatic drive(input logic [5:0] ev, input logic ws, input logic we,
                       input logic [14:0] d);
    evtPulse = ev; wrStatus = ws; wrEnable = we; wrData = d;
    @(negedge clk);
    evtPulse = '0; wrStatus = 1'b0; wrEnable = 1'b0; wrData = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cand, expS, raised;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 status", statusOut, 0);
    chk("R1 enable", enableOut, 0);
    chk("R1 irq", irqOut, 0);
    chk("R1 summary", summaryOut, 0);

    // sweep
    for (int pk = 0; pk < 2; pk++) begin
      pktMode = pk[0];
      for (int pi = 0; pi < 8; pi++) begin
        for (int en = 0; en < 64; en++) begin
          for (int e = 0; e < 6; e++) begin
            int p;
            p = (pi * 21) & 63;
            drive(6'd0, 1'b0, 1'b1, 15'd0);
            drive(6'd0, 1'b1, 1'b0, 15'h7fff);
            drive(p[5:0], 1'b0, 1'b0, 15'd0);
            drive(6'd0, 1'b0, 1'b1, en[14:0]);
            chk("R7 irq after enable write", irqOut, 0);
            drive(6'(1 << e), 1'b0, 1'b0, 15'd0);
            cand   = p | (1 << e);
            raised = ((cand & en) != 0) ? 1 : 0;
            expS   = (raised == 1 && pk == 0) ? (cand & en) : cand;
            chk((raised == 1 && pk == 0) ? "R4 status" : "R2 status", statusOut, expS);
            chk(raised == 1 ? "R3 irq" : "R5 irq", irqOut, raised);
            chk("R11 summary", summaryOut, raised << BID);
          end
        end
      end
    end

    // partial and full clears
    pktMode = 1'b1;
    drive(6'd0, 1'b0, 1'b1, 15'h3f);
    chk("R7 enable value", enableOut, 15'h3f);
    drive(6'd0, 1'b1, 1'b0, 15'h7fff);
    drive(6'h3f, 1'b0, 1'b0, 15'd0);
    chk("R2 all events", statusOut, 15'h3f);
    drive(6'd0, 1'b1, 1'b0, 15'h05);
    chk("R6 partial clear", statusOut, 15'h3a);
    chk("R8 line stays", irqOut, 1);
    drive(6'd0, 1'b1, 1'b0, 15'h7fff);
    chk("R6 full clear", statusOut, 0);
    chk("R8 line falls", irqOut, 0);
    chk("R8 summary falls", summaryOut, 0);
    drive(6'd0, 1'b0, 1'b1, 15'h5a5a);
    chk("R7 enable 15 bits", enableOut, 15'h5a5a);
    drive(6'd0, 1'b0, 1'b1, 15'h3f);

    // set wins over clear
    drive(6'h04, 1'b0, 1'b0, 15'd0);
    drive(6'h04, 1'b1, 1'b0, 15'h04);
    chk("R9 set wins", statusOut, 15'h04);
    chk("R9 line", irqOut, 1);

    // re-arm
    rxCmdPending = 1'b1;
    drive(6'd0, 1'b1, 1'b0, 15'h04);
    chk("R10 rearm pulse", rxRearm, 1);
    @(negedge clk);
    chk("R10 rearm single", rxRearm, 0);
    drive(6'd0, 1'b1, 1'b0, 15'h04);
    chk("R10 no rx done set", rxRearm, 0);
    drive(6'h04, 1'b0, 1'b0, 15'd0);
    drive(6'd0, 1'b1, 1'b0, 15'h02);
    chk("R10 bit 2 not written", rxRearm, 0);
    rxCmdPending = 1'b0;
    drive(6'd0, 1'b1, 1'b0, 15'h04);
    chk("R10 nothing pending", rxRearm, 0);
    chk("R6 rx done cleared", statusOut, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule